// File: doc/BRIEF.md
# Trace Port Output Controller

This block sits between a trace byte formatter and the trace pins of a chip. Three small configuration registers control it. One turns the port on and picks a pin mode. One selects the line protocol. One sets the port width. While the port is off, the internal trace clock is held low. It is released two cycles after the enable bit is set. In synchronous mode, each formatter byte is split into 1-, 2- or 4-bit beats and driven onto the data pins, least significant bits first. A trace clock is driven beside the data. The asynchronous protocol choices are only stored. No serial line encoder is included.

The byte input is a valid/ready stream. A byte moves when `in_valid` and `in_ready` are both high at a rising edge of `clk`. Once `in_valid` is raised, the source must hold it and keep `in_data` stable until the byte is taken. `in_ready` never depends on `in_valid`. `in_ready` is high only in the last system cycle of a trace clock period, and only when no beat of an earlier byte remains after the current one. Because of this, back-to-back bytes leave no idle beat between them, and a stalled source just sees `in_ready` low. A trace clock period is two `clk` cycles. The data pins change when `trace_clk` falls, so a receiver samples them on the rising edge of `trace_clk`.

Top module: `trace_port_out`

## Requirements
- R1: After reset the port is off, the protocol field reads as 01 (asynchronous), and the width is 1 pin. `trace_clk`, `trace_data` and `in_ready` are all low.
- R2: While the enable bit (bit 0 at config address 0) is 0, `trace_clk`, `trace_data` and `in_ready` stay low, whatever the 2-bit mode field (bits 2:1 at address 0) holds.
- R3: The port runs in synchronous mode only when three conditions all hold: the enable bit is 1, the mode field is non-zero (01, 10 or 11), and the protocol field (bits 1:0 at address 1) is 00. Mode 00, or protocol 01, 10 or 11, is only recorded, and the outputs stay low.
- R4: The trace clock gate opens two cycles after the enable bit is written. `trace_clk` first goes high at the third rising `clk` edge after the edge that captured the write.
- R5: The low nibble written at address 2 sets the width: 0x1 gives 1 pin, 0x2 gives 2 pins, 0x8 gives 4 pins. Any other nibble is ignored, and the previous width is kept. A byte keeps the width that was in force when it was accepted.
- R6: Each byte is sent least significant bits first, in 8, 4 or 2 beats for 1, 2 or 4 pins. Each beat lasts one trace clock period. The data pins change only on a falling edge of `trace_clk`.
- R7: A byte is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high only while `trace_clk` is high and no earlier beat remains after the current one, so consecutive bytes stream without a gap.
- R8: Pins beyond the active width are driven low. All data pins are low when no byte is being shifted.
- R9: When the enable bit is cleared, `trace_clk` and `trace_data` are low on the next cycle, and any partly sent byte is dropped.
- R10: `trace_clk` toggles on every `clk` cycle while synchronous mode is active, and at no other time.
- R11: A write to config address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the trace clock source |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| in_valid | input | 1 | Formatter byte valid |
| in_data | input | 8 | Formatter byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| trace_clk | output | 1 | Trace clock output |
| trace_data | output | 4 | Trace data pins |

## Verification
A wrong gate-delay stage shows within a cycle of the enable write, as `trace_clk` rising one edge early or late. A width register that takes an illegal code shows on the next accepted byte, as the wrong beat count and stray high levels on pins that should be unused. A miscounted beat counter shows within one trace period, because `in_ready` rises at the wrong time and the next byte's bits land on the pins early or late. The bench's behavioural model predicts every pin on every cycle, so any of these faults shows as a mismatch on the first cycle it touches.

// File: rtl/tpo_pkg.sv
package tpo_pkg;

  // Active port width, held in the size register.
  typedef enum logic [1:0] {
    PW_1 = 2'd0,
    PW_2 = 2'd1,
    PW_4 = 2'd2
  } port_w_e;

  typedef struct packed {
    logic    ok;
    port_w_e w;
  } size_dec_t;

  localparam logic [1:0] PROTO_SYNC  = 2'b00;
  localparam logic [1:0] PROTO_RST   = 2'b01;
  localparam logic [1:0] MODE_ASYNC  = 2'b00;

  function automatic int unsigned pw_pins(port_w_e w);
    case (w)
      PW_1:    return 1;
      PW_2:    return 2;
      default: return 4;
    endcase
  endfunction

  // One-hot style size code; anything else is reported as not ok.
  function automatic size_dec_t size_decode(logic [3:0] code);
    size_dec_t r;
    r.ok = 1'b1;
    r.w  = PW_1;
    case (code)
      4'h1:    r.w = PW_1;
      4'h2:    r.w = PW_2;
      4'h8:    r.w = PW_4;
      default: r.ok = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tpo_regs.sv
module tpo_regs
  import tpo_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int CFG_W      = 8,
  parameter int CTRL_ADDR  = 0,
  parameter int PROTO_ADDR = 1,
  parameter int SIZE_ADDR  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic              ctl_en,
  output logic [1:0]        ctl_mode,
  output logic [1:0]        ctl_proto,
  output port_w_e           ctl_width
);

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_PROTO = ADDR_W'(PROTO_ADDR);
  localparam logic [ADDR_W-1:0] A_SIZE  = ADDR_W'(SIZE_ADDR);

  size_dec_t size_in;
  logic      wr_ctrl, wr_proto, wr_size;
  logic      unused_hi;

  assign size_in   = size_decode(cfg_wdata[3:0]);
  assign wr_ctrl   = cfg_we && (cfg_addr == A_CTRL);
  assign wr_proto  = cfg_we && (cfg_addr == A_PROTO);
  assign wr_size   = cfg_we && (cfg_addr == A_SIZE) && size_in.ok;
  assign unused_hi = ^cfg_wdata[CFG_W-1:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en    <= 1'b0;
      ctl_mode  <= MODE_ASYNC;
      ctl_proto <= PROTO_RST;
      ctl_width <= PW_1;
    end else begin
      if (wr_ctrl) begin
        ctl_en   <= cfg_wdata[0];
        ctl_mode <= cfg_wdata[2:1];
      end
      if (wr_proto) ctl_proto <= cfg_wdata[1:0];
      if (wr_size)  ctl_width <= size_in.w;
    end
  end

endmodule

// File: rtl/tpo_clkgate.sv
module tpo_clkgate
  import tpo_pkg::*;
#(
  parameter int GATE_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_en,
  input  logic [1:0] ctl_mode,
  input  logic [1:0] ctl_proto,
  output logic       gate_on,
  output logic       sync_on
);

  logic [GATE_STAGES-1:0] stage_q;

  // Delay chain: each stage also needs enable still high, so a brief
  // drop of the enable restarts the whole delay.
  generate
    for (genvar i = 0; i < GATE_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= ctl_en;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b0;
          else        stage_q[i] <= stage_q[i-1] & ctl_en;
        end
      end
    end
  endgenerate

  // Gate removed combinationally the moment the enable drops.
  assign gate_on = ctl_en & stage_q[GATE_STAGES-1];
  assign sync_on = gate_on && (ctl_mode != MODE_ASYNC) && (ctl_proto == PROTO_SYNC);

endmodule

// File: rtl/tpo_shifter.sv
module tpo_shifter
  import tpo_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PINS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_on,
  input  port_w_e           ctl_width,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              trace_clk,
  output logic [PINS-1:0]   trace_data,
  output port_w_e           lat_width
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic              phase_q;
  logic              busy_q;
  logic [CNT_W-1:0]  beats_q;
  logic [BYTE_W-1:0] sh_q;
  logic              last_beat;
  logic              take;
  logic [PINS-1:0]   pin_on;

  assign last_beat = (beats_q == CNT_W'(1));
  assign in_ready  = sync_on & phase_q & (~busy_q | last_beat);
  assign take      = in_valid & in_ready;
  assign trace_clk = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= 1'b0;
      busy_q    <= 1'b0;
      beats_q   <= '0;
      sh_q      <= '0;
      lat_width <= PW_1;
    end else if (!sync_on) begin
      phase_q <= 1'b0;
      busy_q  <= 1'b0;
      beats_q <= '0;
    end else begin
      phase_q <= ~phase_q;
      if (phase_q) begin
        if (busy_q && !last_beat) begin
          beats_q <= beats_q - CNT_W'(1);
          case (lat_width)
            PW_1:    sh_q <= sh_q >> 1;
            PW_2:    sh_q <= sh_q >> 2;
            default: sh_q <= sh_q >> 4;
          endcase
        end else if (take) begin
          sh_q      <= in_data;
          lat_width <= ctl_width;
          beats_q   <= CNT_W'(BYTE_W / int'(pw_pins(ctl_width)));
          busy_q    <= 1'b1;
        end else begin
          busy_q  <= 1'b0;
          beats_q <= '0;
        end
      end
    end
  end

  generate
    for (genvar i = 0; i < PINS; i++) begin : g_pin
      assign pin_on[i]     = (32'(i) < pw_pins(lat_width));
      assign trace_data[i] = busy_q & pin_on[i] & sh_q[i];
    end
  endgenerate

endmodule

// File: rtl/trace_port_out.sv
module trace_port_out
  import tpo_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int CFG_W       = 8,
  parameter int BYTE_W      = 8,
  parameter int PINS        = 4,
  parameter int GATE_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              trace_clk,
  output logic [PINS-1:0]   trace_data
);

  logic       ctl_en;
  logic [1:0] ctl_mode;
  logic [1:0] ctl_proto;
  port_w_e    ctl_width;
  port_w_e    lat_width;
  logic       gate_on;
  logic       sync_on;

  tpo_regs #(
    .ADDR_W(ADDR_W), .CFG_W(CFG_W),
    .CTRL_ADDR(0), .PROTO_ADDR(1), .SIZE_ADDR(2)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ctl_en(ctl_en), .ctl_mode(ctl_mode), .ctl_proto(ctl_proto),
    .ctl_width(ctl_width)
  );

  tpo_clkgate #(.GATE_STAGES(GATE_STAGES)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .ctl_en(ctl_en), .ctl_mode(ctl_mode), .ctl_proto(ctl_proto),
    .gate_on(gate_on), .sync_on(sync_on)
  );

  tpo_shifter #(.BYTE_W(BYTE_W), .PINS(PINS)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sync_on(sync_on), .ctl_width(ctl_width),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .trace_clk(trace_clk), .trace_data(trace_data),
    .lat_width(lat_width)
  );

endmodule

// File: rtl/trace_port_out_chk.sv
module trace_port_out_chk
  import tpo_pkg::*;
#(
  parameter int PINS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ctl_en,
  input logic            gate_on,
  input logic            sync_on,
  input port_w_e         lat_width,
  input logic            in_ready,
  input logic            trace_clk,
  input logic [PINS-1:0] trace_data
);

  // R4: gate only open after enable has been high for two cycles
  p_gate_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on |-> ($past(ctl_en, 1) && $past(ctl_en, 2)));

  // R9: clearing enable silences the port on the next cycle
  p_disable_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> (!trace_clk && trace_data == '0));

  // R2 / R3: no handshake outside synchronous mode
  p_no_ready_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_on |-> !in_ready);

  // R10: outputs fall quiet one cycle after synchronous mode ends
  p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_on |=> (!trace_clk && trace_data == '0));

  // R10: clock toggles every cycle while synchronous mode persists
  p_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_on && $past(sync_on)) |-> (trace_clk != $past(trace_clk)));

  // R7: bytes are only taken in the high half of the trace clock
  p_ready_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> trace_clk);

  // R6: data held through the low half of a trace clock period
  p_beat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_on && !trace_clk) |=> $stable(trace_data));

  // R8: pins beyond the width of the byte in flight stay low
  p_unused_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_width == PW_1) |-> ((trace_data >> 1) == '0));

  p_unused2_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_width == PW_2) |-> ((trace_data >> 2) == '0));

endmodule

bind trace_port_out trace_port_out_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .gate_on(gate_on),
  .sync_on(sync_on), .lat_width(lat_width), .in_ready(in_ready),
  .trace_clk(trace_clk), .trace_data(trace_data)
);

// File: tb/trace_port_out_test.sv
`timescale 1ns/1ps
module trace_port_out_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic       trace_clk;
  logic [3:0] trace_data;

  always #4 clk = ~clk;  // 125 MHz

  trace_port_out uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .trace_clk(trace_clk), .trace_data(trace_data)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string cur_req = "R1";

  // Behavioural reference state
  int m_en = 0, m_mode = 0, m_proto = 1, m_pins = 1;
  int m_g1 = 0, m_g2 = 0, m_ph = 0, m_busy = 0, m_cur = 0;
  int m_q[$];
  logic [7:0] src_q[$];

  function automatic int m_active();
    return (m_en != 0 && m_g2 != 0 && m_mode != 0 && m_proto == 0) ? 1 : 0;
  endfunction

  function automatic int m_ready();
    return (m_active() != 0 && m_ph != 0 && m_q.size() == 0) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_mode = 0; m_proto = 1; m_pins = 1;
      m_g1 = 0; m_g2 = 0; m_ph = 0; m_busy = 0; m_cur = 0;
      m_q.delete();
    end else begin
      int act, rdy, old_en, old_g1;
      act = m_active();
      rdy = m_ready();
      if (act != 0) begin
        if (m_ph != 0) begin
          if (m_q.size() > 0) begin
            m_cur = m_q.pop_front();
          end else if (in_valid && rdy != 0) begin
            for (int k = 0; k < 8 / m_pins; k++)
              m_q.push_back((int'(in_data) >> (k * m_pins)) & ((1 << m_pins) - 1));
            m_cur  = m_q.pop_front();
            m_busy = 1;
            void'(src_q.pop_front());
          end else begin
            m_busy = 0;
          end
        end
        m_ph = (m_ph != 0) ? 0 : 1;
      end else begin
        m_ph = 0; m_busy = 0; m_q.delete();
      end
      old_en = m_en; old_g1 = m_g1;
      m_g2 = (old_en != 0 && old_g1 != 0) ? 1 : 0;
      m_g1 = old_en;
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: begin m_en = int'(cfg_wdata[0]); m_mode = int'(cfg_wdata[2:1]); end
          2'd1: m_proto = int'(cfg_wdata[1:0]);
          2'd2: case (cfg_wdata[3:0])
                  4'h1: m_pins = 1;
                  4'h2: m_pins = 2;
                  4'h8: m_pins = 4;
                  default: ;
                endcase
          default: ;  // R11: address 3 has no effect
        endcase
      end
    end
  end

  // Compare every cycle away from the active edge, then drive the source.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e_clk, e_rdy, e_dat;
      e_clk = m_ph;
      e_rdy = m_ready();
      e_dat = (m_busy != 0) ? m_cur : 0;
      n_tests++;
      if (int'(trace_clk) != e_clk || int'(in_ready) != e_rdy || int'(trace_data) != e_dat) begin
        n_fail++;
        $display("FAIL %s t=%0t clk/rdy/data actual %0d/%0d/%h expected %0d/%0d/%h",
                 cur_req, $time, trace_clk, in_ready, trace_data, e_clk, e_rdy, e_dat);
      end
    end
    in_valid = (src_q.size() > 0);
    in_data  = (src_q.size() > 0) ? src_q[0] : 8'h00;
  end

  task automatic check(input string req, input bit ok, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    // R1: reset state
    cur_req = "R1";
    @(negedge clk);
    check("R1", trace_clk == 0 && trace_data == 0 && in_ready == 0,
          int'({trace_clk, in_ready, trace_data}), 0);
    idle(4);

    // R3: enabled, mode 01, but protocol still at its asynchronous reset value
    cur_req = "R3";
    wr(2'd0, 8'h03);
    src_q.push_back(8'h5A);
    idle(20);
    check("R3", trace_clk == 0 && in_ready == 0, int'(trace_clk), 0);
    wr(2'd1, 8'h02);
    idle(10);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h01);  // mode 00 with sync protocol: still quiet
    idle(16);
    check("R3", trace_clk == 0 && trace_data == 0, int'(trace_clk), 0);

    // R2: mode 11 but enable off
    cur_req = "R2";
    wr(2'd0, 8'h06);
    idle(16);
    check("R2", trace_clk == 0 && in_ready == 0, int'(trace_clk), 0);

    // R4: gate delay, counted from the edge that captures the write
    cur_req = "R4";
    begin
      int n;
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 8'h03;
      @(negedge clk);
      cfg_we = 1'b0;
      n = 0;
      while (n < 10) begin
        @(posedge clk); n++;
        @(negedge clk);
        if (trace_clk) break;
      end
      check("R4", n == 3, n, 3);
    end

    // R6 / R10: pending byte then more at 1 pin
    cur_req = "R6";
    src_q.push_back(8'hC3);
    idle(60);

    // R5: width changes, including an ignored code
    cur_req = "R5";
    wr(2'd2, 8'h02);
    src_q.push_back(8'h96); src_q.push_back(8'h1E);
    idle(40);
    wr(2'd2, 8'h08);
    src_q.push_back(8'hA7);
    idle(20);
    wr(2'd2, 8'h04);  // ignored: stays at 4 pins
    src_q.push_back(8'h3C);
    idle(20);
    wr(2'd2, 8'hF3);  // ignored
    src_q.push_back(8'hE1);
    idle(20);

    // R7 / R8: back-to-back stream, then a gap
    cur_req = "R7";
    for (int i = 0; i < 6; i++) src_q.push_back(8'(8'h11 * i + 8'h0F));
    idle(40);
    cur_req = "R8";
    wr(2'd2, 8'h01);
    src_q.push_back(8'hFF);
    idle(40);
    wr(2'd2, 8'h02);
    src_q.push_back(8'hFF);
    idle(30);

    // R9: drop enable mid-byte, then restart
    cur_req = "R9";
    wr(2'd2, 8'h01);
    src_q.push_back(8'hB5); src_q.push_back(8'h4D);
    idle(7);
    wr(2'd0, 8'h02);
    @(negedge clk);
    check("R9", trace_clk == 0 && trace_data == 0, int'({trace_clk, trace_data}), 0);
    idle(6);
    wr(2'd0, 8'h05);
    idle(60);

    // R11: address 3 writes change nothing
    cur_req = "R11";
    wr(2'd3, 8'h00);
    src_q.push_back(8'h69);
    idle(40);
    check("R11", src_q.size() == 0, src_q.size(), 0);

    // R10: switching protocol away silences the clock
    cur_req = "R10";
    wr(2'd1, 8'h01);
    idle(6);
    check("R10", trace_clk == 0, int'(trace_clk), 0);
    wr(2'd1, 8'h00);
    idle(12);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_fail++; n_tests++;
      $display("FAIL watchdog actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule